// File: doc/BRIEF.md
# Grouped Data Bus Inversion Encoder

This block prepares a 64-bit logical data word for an active-low host data bus. On that bus a logical 1 is a low wire. To cap the number of low wires, the word is cut into four 16-bit groups. For each group the block decides whether to send it as is or inverted. A group is inverted when it would otherwise pull more than half of its lines low. Each group has its own active-low inversion flag, and that flag leaves the block in the same cycle as the data it qualifies.

The encoder registers its result with one cycle of latency. A valid bit travels alongside the data. When no word is offered, the wire outputs hold their last value.

A matching combinational decoder in the same top takes wire levels and flags and rebuilds the logical word. A receiver uses it directly, and a bench uses it for loopback.

Top module: `dbi_bus_encoder`

## Requirements
- R1: Inversion flag k (bit k of `wire_flag_n`) governs data bits [16k+15:16k], so flag 0 belongs to bits 15:0 and flag 3 belongs to bits 63:48.
- R2: Whenever `valid_out` is 1, each 16-bit group of `wire_data` has at most 8 bits at 0 (low wires). The flag wire is not counted.
- R3: If a group of the accepted word holds more than 8 logical ones, that group is sent inverted (wire bit equals logical bit) and its flag is driven 0.
- R4: If a group holds 8 or fewer logical ones, including exactly 8, it is sent non-inverted and its flag is driven 1.
- R5: In a non-inverted group each wire bit is the complement of the logical bit (logical 1 gives wire 0).
- R6: `valid_out` equals `valid_in` from one clock earlier. Wire data and flags for a word accepted at edge n appear after edge n, and they hold unchanged while `valid_in` is 0.
- R7: The decoder output `rx_data` equals, per group, the complement of `rx_wire_data` XOR the asserted state of its flag, so it returns the original word after encoding.
- R8: While `rst` is 1 at a clock edge, `valid_out` becomes 0 and every data and flag wire becomes 1 (released high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | A word is offered this cycle |
| data_in | input | 64 | Logical data word |
| valid_out | output | 1 | Encoded word present on the wires |
| wire_data | output | 64 | Wire levels, 0 = low |
| wire_flag_n | output | 4 | Active-low inversion flags, one per group |
| rx_wire_data | input | 64 | Wire levels seen by the decoder |
| rx_flag_n | input | 4 | Flags seen by the decoder |
| rx_data | output | 64 | Recovered logical word |

## Verification
The bench builds the block with its default values, a 64-bit word in 16-bit groups, so the inversion threshold is 8. Those values bring into reach the exact-threshold case (8 ones kept, 9 inverted), patterns in which only one group's flag falls, and the all-ones word that forces all four groups to invert at once. Every encoded word is looped back through the decoder ports, so the decoder is tested on real encoder output.

// File: rtl/dbi_pkg.sv
package dbi_pkg;

    localparam int DBI_DATA_W  = 64;
    localparam int DBI_GROUP_W = 16;

    // How one group is placed on the wires
    typedef enum logic {
        SEND_TRUE     = 1'b0,
        SEND_INVERTED = 1'b1
    } dbi_sel_e;

endpackage

// File: rtl/dbi_group_enc.sv
module dbi_group_enc
    import dbi_pkg::*;
#(
    parameter int GROUP_W = DBI_GROUP_W
) (
    input  logic [GROUP_W-1:0] data,
    output logic [GROUP_W-1:0] wire_lvl,
    output logic               flag_n
);
    localparam int CNT_W = $clog2(GROUP_W + 1);
    localparam logic [CNT_W-1:0] LOW_LIMIT = CNT_W'(GROUP_W / 2);

    logic [CNT_W-1:0] ones;
    dbi_sel_e         sel;

    // Logical ones are the wires that would be low if sent as is
    always_comb begin
        ones = '0;
        for (int i = 0; i < GROUP_W; i++) begin
            ones = ones + CNT_W'(data[i]);
        end
    end

    always_comb begin
        sel      = (ones > LOW_LIMIT) ? SEND_INVERTED : SEND_TRUE;
        wire_lvl = (sel == SEND_INVERTED) ? data : ~data;
        flag_n   = (sel != SEND_INVERTED);
    end

endmodule

// File: rtl/dbi_group_dec.sv
module dbi_group_dec
    import dbi_pkg::*;
#(
    parameter int GROUP_W = DBI_GROUP_W
) (
    input  logic [GROUP_W-1:0] wire_lvl,
    input  logic               flag_n,
    output logic [GROUP_W-1:0] data
);
    // Undo the active-low level, then undo the group inversion
    always_comb begin
        data = (~wire_lvl) ^ {GROUP_W{~flag_n}};
    end

endmodule

// File: rtl/dbi_bus_encoder.sv
module dbi_bus_encoder
    import dbi_pkg::*;
#(
    parameter int DATA_W  = DBI_DATA_W,
    parameter int GROUP_W = DBI_GROUP_W
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           valid_in,
    input  logic [DATA_W-1:0]              data_in,
    output logic                           valid_out,
    output logic [DATA_W-1:0]              wire_data,
    output logic [DATA_W/GROUP_W-1:0]      wire_flag_n,
    input  logic [DATA_W-1:0]              rx_wire_data,
    input  logic [DATA_W/GROUP_W-1:0]      rx_flag_n,
    output logic [DATA_W-1:0]              rx_data
);
    localparam int NUM_GROUPS = DATA_W / GROUP_W;

    logic [DATA_W-1:0]     next_wire;
    logic [NUM_GROUPS-1:0] next_flag_n;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        dbi_group_enc #(.GROUP_W(GROUP_W)) i_enc (
            .data     (data_in[g*GROUP_W +: GROUP_W]),
            .wire_lvl (next_wire[g*GROUP_W +: GROUP_W]),
            .flag_n   (next_flag_n[g])
        );

        dbi_group_dec #(.GROUP_W(GROUP_W)) i_dec (
            .wire_lvl (rx_wire_data[g*GROUP_W +: GROUP_W]),
            .flag_n   (rx_flag_n[g]),
            .data     (rx_data[g*GROUP_W +: GROUP_W])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_out   <= 1'b0;
            wire_data   <= '1;
            wire_flag_n <= '1;
        end else begin
            valid_out <= valid_in;
            if (valid_in) begin
                wire_data   <= next_wire;
                wire_flag_n <= next_flag_n;
            end
        end
    end

endmodule

// File: rtl/dbi_bus_encoder_chk.sv
module dbi_bus_encoder_chk #(
    parameter int DATA_W  = 64,
    parameter int GROUP_W = 16
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      valid_in,
    input logic [DATA_W-1:0]         data_in,
    input logic                      valid_out,
    input logic [DATA_W-1:0]         wire_data,
    input logic [DATA_W/GROUP_W-1:0] wire_flag_n
);
    localparam int NUM_GROUPS = DATA_W / GROUP_W;
    localparam int HALF       = GROUP_W / 2;

    assert_valid_delay_R6: assert property (@(posedge clk) disable iff (rst)
        valid_in |=> valid_out);

    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !valid_in |=> ($stable(wire_data) && $stable(wire_flag_n) && !valid_out));

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_chk
        assert_low_limit_R2: assert property (@(posedge clk) disable iff (rst)
            valid_out |-> ($countones(~wire_data[g*GROUP_W +: GROUP_W]) <= HALF));

        assert_invert_flag_R3: assert property (@(posedge clk) disable iff (rst)
            (valid_in && ($countones(data_in[g*GROUP_W +: GROUP_W]) > HALF))
            |=> !wire_flag_n[g]);

        assert_keep_flag_R4: assert property (@(posedge clk) disable iff (rst)
            (valid_in && ($countones(data_in[g*GROUP_W +: GROUP_W]) <= HALF))
            |=> wire_flag_n[g]);
    end

endmodule

bind dbi_bus_encoder dbi_bus_encoder_chk #(.DATA_W(DATA_W), .GROUP_W(GROUP_W)) i_chk (
    .clk         (clk),
    .rst         (rst),
    .valid_in    (valid_in),
    .data_in     (data_in),
    .valid_out   (valid_out),
    .wire_data   (wire_data),
    .wire_flag_n (wire_flag_n)
);

// File: tb/test_dbi_bus_encoder.sv
module test_dbi_bus_encoder;
    localparam int DW = 64;
    localparam int GW = 16;
    localparam int NG = DW / GW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          valid_in = 1'b0;
    logic [DW-1:0] data_in = '0;
    logic          valid_out;
    logic [DW-1:0] wire_data;
    logic [NG-1:0] wire_flag_n;
    logic [DW-1:0] rx_data;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] q_data[$];
    logic [DW-1:0] last_wire = '1;
    logic [NG-1:0] last_flag = '1;

    always #10 clk = ~clk;   // 50 MHz

    dbi_bus_encoder #(.DATA_W(DW), .GROUP_W(GW)) i_dbi_bus_encoder (
        .clk          (clk),
        .rst          (rst),
        .valid_in     (valid_in),
        .data_in      (data_in),
        .valid_out    (valid_out),
        .wire_data    (wire_data),
        .wire_flag_n  (wire_flag_n),
        .rx_wire_data (wire_data),
        .rx_flag_n    (wire_flag_n),
        .rx_data      (rx_data)
    );

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic void model(input logic [DW-1:0] d, output logic [DW-1:0] w, output logic [NG-1:0] f);
        for (int g = 0; g < NG; g++) begin
            logic [GW-1:0] seg;
            bit inv;
            seg = d[g*GW +: GW];
            inv = $countones(seg) > GW / 2;
            w[g*GW +: GW] = inv ? seg : ~seg;
            f[g] = ~inv;
        end
    endfunction

    task automatic drive(input logic [DW-1:0] d);
        @(negedge clk);
        data_in  = d;
        valid_in = 1'b1;
        q_data.push_back(d);
        @(negedge clk);
        valid_in = 1'b0;
        data_in  = ~d;
    endtask

    // Monitor: pop and compare each encoded word
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (!rst && valid_out) begin
                if (q_data.size() == 0) begin
                    chk(1'b0, "R6 unexpected valid_out", 64'd1, 64'd0);
                end else begin
                    logic [DW-1:0] d, ew;
                    logic [NG-1:0] ef;
                    d = q_data.pop_front();
                    model(d, ew, ef);
                    chk(wire_data === ew, "R3/R4/R5 wire data", wire_data, ew);
                    chk(wire_flag_n === ef, "R1 flags", {60'd0, wire_flag_n}, {60'd0, ef});
                    for (int g = 0; g < NG; g++) begin
                        int lows;
                        lows = $countones(~wire_data[g*GW +: GW]);
                        chk(lows <= GW / 2, "R2 low wires per group", 64'(lows), 64'(GW / 2));
                    end
                    chk(rx_data === d, "R7 decoder loopback", rx_data, d);
                    last_wire = ew;
                    last_flag = ef;
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #5;
        chk(valid_out === 1'b0, "R8 reset valid_out", {63'd0, valid_out}, 64'd0);
        chk(wire_data === '1, "R8 reset wire_data", wire_data, '1);
        chk(wire_flag_n === '1, "R8 reset flags", {60'd0, wire_flag_n}, 64'hF);
        @(negedge clk);
        rst = 1'b0;

        drive(64'h0);                       // R4 nothing inverted
        drive(64'hFFFF_FFFF_FFFF_FFFF);     // R3 all groups inverted
        drive(64'h5555_5555_5555_5555);     // R4 exactly 8
        drive(64'hAAAA_AAAA_AAAA_AAAA);     // R4 exactly 8
        drive(64'h01FF_00FF_01FF_00FF);     // R3/R4 9 vs 8 ones
        drive(64'hFFFF_0000_0000_0000);     // R1 only flag 3
        drive(64'h0000_0000_0000_FFFF);     // R1 only flag 0
        drive(64'h0000_FFFE_0000_0000);     // R1 only flag 2 (15 ones)
        drive(64'h0000_0000_FF80_0000);     // R1 only flag 1 (9 ones)
        for (int i = 0; i < 40; i++) begin
            drive({$urandom(), $urandom()});
        end
        // Back-to-back words
        @(negedge clk);
        valid_in = 1'b1;
        data_in  = 64'h1234_FFF0_8001_7FFF;
        q_data.push_back(data_in);
        @(negedge clk);
        data_in  = 64'hFEDC_0F0F_FFFF_0001;
        q_data.push_back(data_in);
        @(negedge clk);
        valid_in = 1'b0;
        data_in  = '1;

        repeat (3) @(negedge clk);
        chk(q_data.size() == 0, "R6 all words delivered", 64'(q_data.size()), 64'd0);
        chk(valid_out === 1'b0, "R6 idle valid_out", {63'd0, valid_out}, 64'd0);
        chk(wire_data === last_wire, "R6 idle hold data", wire_data, last_wire);
        chk(wire_flag_n === last_flag, "R6 idle hold flags", {60'd0, wire_flag_n}, {60'd0, last_flag});

        // R8 reset mid-run
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(wire_data === '1 && wire_flag_n === '1 && valid_out === 1'b0,
            "R8 reset after traffic", wire_data, '1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule